// File: doc/BRIEF.md
# Byte Add Instruction Executor

This block runs a single 8-bit two's-complement add instruction against its own 256-byte register file. A byte stream with a valid/ready handshake carries the instruction: first the opcode byte, then one or two operand bytes. The opcode selects how the two operands are found. They can be two working registers, a working register used as a pointer, two absolute registers, an absolute register used as a pointer, or an immediate byte. The block adds the source to the destination and stores the sum in the destination. It also updates a six-bit flag register. When the cycle count for that instruction form has run out, it raises a one-clock done pulse.

The working registers are sixteen consecutive locations. They start at a base address taken from a configuration input, so working register n sits at address base + n. They are therefore separate from the low absolute addresses. A test-load port lets a bench or boot sequence write any location and read any location back.

Top module: `byte_add_exec`

## Requirements
- R1: The 8-bit sum destination + source, taken modulo 256, is written to the destination location. The source location keeps its value, unless it is the same location as the destination.
- R2: The `flags` output is {C,Z,S,V,D,H}, from bit 5 down to bit 0. After each add: C is the carry out of bit 7, Z is set when the result is 00h, S equals result bit 7, H is the carry out of bit 3, and D is 0. The flags change only in the cycle in which `done` rises.
- R3: V is 1 exactly when both operands have the same bit 7 and the result's bit 7 differs from it.
- R4: Opcode 02h (working + working) and opcode 03h (working + byte pointed to by a working register) each have one operand byte. Its bits 7:4 give the destination working register and bits 3:0 give the source working register. Working register n is address `wr_base` + n.
- R5: Opcodes 04h (absolute + absolute) and 05h (absolute + byte pointed to by an absolute register) take the source address in the first operand byte and the destination address in the second.
- R6: Opcode 06h takes the destination address in the first operand byte and the immediate addend in the second.
- R7: Count the cycle that accepts the opcode as cycle 1. `done` is high for exactly one clock, in the cycle after cycle N. N is 4 for opcode 02h and 6 for opcodes 03h–06h. Each cycle spent waiting for an operand byte adds one cycle.
- R8: `in_ready` is low from the cycle after the last operand byte is accepted until `done` is high.
- R9: Any opcode other than 02h–06h raises `err` for one clock in the cycle after it is accepted. It leaves the registers and flags as they were, and `in_ready` stays high so the next byte is taken as an opcode.
- R10: With `tl_we` high, `tl_wdata` is written to `tl_addr` at the clock edge. `tl_rdata` shows the location at `tl_raddr` without delay.
- R11: During reset and right after it, `flags` is 0, `done` and `err` are low, `in_ready` is high, and every register-file location is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Opcode or operand byte |
| in_ready | output | 1 | Block can take a byte |
| wr_base | input | 8 | Working-register base address, low nibble zero |
| tl_we | input | 1 | Test-load write enable |
| tl_addr | input | 8 | Test-load write address |
| tl_wdata | input | 8 | Test-load write data |
| tl_raddr | input | 8 | Test read address |
| tl_rdata | output | 8 | Register-file contents at tl_raddr |
| flags | output | 6 | {C,Z,S,V,D,H} |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock illegal-opcode pulse |

## Verification
The sum, the new flags and `done` all show up in one and the same cycle. With back-to-back bytes, that is N−1 clock edges after the edge that took the opcode, plus one edge for each cycle the bench leaves `in_valid` low between operand bytes. The driver notes the cycle counter at the opcode edge and stores the due cycle with each expected item. The monitor pops that item on the falling edge where `done` is high and compares the counter with it before reading the destination and source back through the test port. The `err` pulse is due on the first falling edge after the illegal opcode is taken, and it must be gone one edge later.

// File: rtl/bae_pkg.sv
package bae_pkg;
    localparam int DW        = 8;
    localparam int AW        = 8;
    localparam int NIB       = 4;
    localparam int CYC_SHORT = 4;
    localparam int CYC_LONG  = 6;
    localparam int CW        = $clog2(CYC_LONG + 1);

    typedef enum logic [2:0] {
        MD_WW, MD_WPW, MD_AA, MD_APA, MD_IMA, MD_BAD
    } mode_e;

    typedef enum logic [1:0] {PH_IDLE, PH_ARGS, PH_EXEC} phase_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic d;
        logic h;
    } flags_t;

    function automatic mode_e op_mode(input logic [DW-1:0] op);
        case (op)
            8'h02:   return MD_WW;
            8'h03:   return MD_WPW;
            8'h04:   return MD_AA;
            8'h05:   return MD_APA;
            8'h06:   return MD_IMA;
            default: return MD_BAD;
        endcase
    endfunction

    function automatic logic [CW-1:0] op_cycles(input mode_e m);
        return (m == MD_WW) ? CW'(CYC_SHORT) : CW'(CYC_LONG);
    endfunction

    function automatic logic [1:0] op_args(input mode_e m);
        return (m == MD_WW || m == MD_WPW) ? 2'd1 : 2'd2;
    endfunction
endpackage

// File: rtl/bae_regfile.sv
module bae_regfile
    import bae_pkg::*;
#(
    parameter int W = DW,
    parameter int A = AW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         core_we,
    input  logic [A-1:0] core_addr,
    input  logic [W-1:0] core_wdata,
    input  logic         tl_we,
    input  logic [A-1:0] tl_addr,
    input  logic [W-1:0] tl_wdata,
    input  logic [A-1:0] dst_addr,
    output logic [W-1:0] dst_data,
    input  logic [A-1:0] src_addr,
    output logic [W-1:0] src_data,
    output logic [W-1:0] ind_data,
    input  logic [A-1:0] peek_addr,
    output logic [W-1:0] peek_data
);
    localparam int DEPTH = 1 << A;

    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    // The core's write is placed last, so it wins over a test write to the same address.
    always_comb begin
        mem_d = mem_q;
        if (tl_we)   mem_d[tl_addr]   = tl_wdata;
        if (core_we) mem_d[core_addr] = core_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign dst_data  = mem_q[dst_addr];
    assign src_data  = mem_q[src_addr];
    assign ind_data  = mem_q[A'(src_data)];
    assign peek_data = mem_q[peek_addr];

    // R10: a test write that the core does not override lands at the next edge
    assert_tl_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_we && !(core_we && core_addr == tl_addr)) |=> mem_q[$past(tl_addr)] == $past(tl_wdata));
endmodule

// File: rtl/bae_adder.sv
module bae_adder
    import bae_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output flags_t       fl
);
    logic [W:0]   full;
    logic [NIB:0] low;

    always_comb begin
        full = {1'b0, a} + {1'b0, b};
        low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
        sum  = full[W-1:0];
        fl.c = full[W];
        fl.z = (full[W-1:0] == '0);
        fl.s = full[W-1];
        fl.v = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
        fl.d = 1'b0;
        fl.h = low[NIB];
    end
endmodule

// File: rtl/bae_ctrl.sv
module bae_ctrl
    import bae_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    output logic          in_ready,
    input  logic [AW-1:0] wr_base,
    output logic [AW-1:0] dst_addr,
    output logic [AW-1:0] src_addr,
    input  logic [DW-1:0] dst_data,
    input  logic [DW-1:0] src_data,
    input  logic [DW-1:0] ind_data,
    output logic [DW-1:0] op_a,
    output logic [DW-1:0] op_b,
    input  logic [DW-1:0] sum,
    input  flags_t        sum_fl,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output flags_t        flags,
    output logic          done,
    output logic          err
);
    typedef struct packed {
        phase_e        ph;
        mode_e         mode;
        logic [CW-1:0] cnt;
        logic [1:0]    got;
        logic [DW-1:0] b1;
        logic [DW-1:0] b2;
        logic          done;
        logic          err;
        flags_t        fl;
    } ctrl_t;

    ctrl_t s_q, s_d;
    logic  accept;

    always_comb begin
        in_ready = (s_q.ph != PH_EXEC);
        accept   = in_valid && in_ready;

        // operand addressing
        case (s_q.mode)
            MD_WW, MD_WPW: begin
                dst_addr = wr_base + AW'(s_q.b1[DW-1:NIB]);
                src_addr = wr_base + AW'(s_q.b1[NIB-1:0]);
            end
            MD_AA, MD_APA: begin
                dst_addr = s_q.b2;
                src_addr = s_q.b1;
            end
            default: begin
                dst_addr = s_q.b1;
                src_addr = s_q.b1;
            end
        endcase
        op_a = dst_data;
        case (s_q.mode)
            MD_WW, MD_AA:   op_b = src_data;
            MD_WPW, MD_APA: op_b = ind_data;
            default:        op_b = s_q.b2;
        endcase
        wr_data = sum;
        wr_en   = 1'b0;

        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        case (s_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    if (op_mode(in_byte) == MD_BAD) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.mode = op_mode(in_byte);
                        s_d.cnt  = CW'(1);
                        s_d.got  = 2'd0;
                        s_d.ph   = PH_ARGS;
                    end
                end
            end
            PH_ARGS: begin
                if (accept) begin
                    if (s_q.got == 2'd0) s_d.b1 = in_byte;
                    else                 s_d.b2 = in_byte;
                    s_d.got = s_q.got + 2'd1;
                    s_d.cnt = s_q.cnt + CW'(1);
                    if (s_q.got + 2'd1 == op_args(s_q.mode)) s_d.ph = PH_EXEC;
                end
            end
            PH_EXEC: begin
                if (s_q.cnt == op_cycles(s_q.mode) - CW'(1)) begin
                    wr_en    = 1'b1;
                    s_d.fl   = sum_fl;
                    s_d.done = 1'b1;
                    s_d.ph   = PH_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt + CW'(1);
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, mode: MD_BAD, cnt: '0, got: '0, b1: '0, b2: '0,
                     done: 1'b0, err: 1'b0, fl: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign flags = s_q.fl;
    assign done  = s_q.done;
    assign err   = s_q.err;

    // R7: completion is a single-clock pulse
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    // R2: flags move only together with done
    assert_flags_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.fl) |-> s_q.done);
    // R9: an illegal opcode leaves the flags alone
    assert_err_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |-> $stable(s_q.fl));
    // R9: error and completion never coincide
    assert_no_done_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.done && s_q.err));
    // R8: input was held off in the final cycle of execution
    assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !$past(in_ready));
endmodule

// File: rtl/byte_add_exec.sv
module byte_add_exec
    import bae_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_byte,
    output logic          in_ready,
    input  logic [AW-1:0] wr_base,
    input  logic          tl_we,
    input  logic [AW-1:0] tl_addr,
    input  logic [DW-1:0] tl_wdata,
    input  logic [AW-1:0] tl_raddr,
    output logic [DW-1:0] tl_rdata,
    output logic [5:0]    flags,
    output logic          done,
    output logic          err
);
    logic [AW-1:0] dst_addr, src_addr;
    logic [DW-1:0] dst_data, src_data, ind_data;
    logic [DW-1:0] op_a, op_b, sum, wr_data;
    logic          wr_en;
    flags_t        sum_fl, fl_q;

    bae_regfile #(.W(DW), .A(AW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .core_we(wr_en), .core_addr(dst_addr), .core_wdata(wr_data),
        .tl_we(tl_we), .tl_addr(tl_addr), .tl_wdata(tl_wdata),
        .dst_addr(dst_addr), .dst_data(dst_data),
        .src_addr(src_addr), .src_data(src_data), .ind_data(ind_data),
        .peek_addr(tl_raddr), .peek_data(tl_rdata)
    );

    bae_adder #(.W(DW)) u_add (
        .a(op_a), .b(op_b), .sum(sum), .fl(sum_fl)
    );

    bae_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .wr_base(wr_base),
        .dst_addr(dst_addr), .src_addr(src_addr),
        .dst_data(dst_data), .src_data(src_data), .ind_data(ind_data),
        .op_a(op_a), .op_b(op_b), .sum(sum), .sum_fl(sum_fl),
        .wr_en(wr_en), .wr_data(wr_data),
        .flags(fl_q), .done(done), .err(err)
    );

    assign flags = fl_q;
endmodule

// File: tb/byte_add_exec_test.sv
module byte_add_exec_test;
    localparam int PERIOD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ready;
    logic [7:0] wr_base = 8'hC0;
    logic       tl_we = 1'b0;
    logic [7:0] tl_addr = '0, tl_wdata = '0, tl_raddr = '0;
    logic [7:0] tl_rdata;
    logic [5:0] flags;
    logic       done, err;

    byte_add_exec uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .wr_base(wr_base), .tl_we(tl_we), .tl_addr(tl_addr),
        .tl_wdata(tl_wdata), .tl_raddr(tl_raddr), .tl_rdata(tl_rdata),
        .flags(flags), .done(done), .err(err)
    );

    always #(PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [7:0] d, v, sa, sv;
        logic [5:0] fl;
        bit         chk_src;
        int         due;
        string      req;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] mdl [256];
    int         n_vec = 0, n_bad = 0;
    bit         ended = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h, expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_flags(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] f;
        logic [4:0] l;
        f = {1'b0, a} + {1'b0, b};
        l = {1'b0, a[3:0]} + {1'b0, b[3:0]};
        return {f[8], f[7:0] == 8'h00, f[7], (a[7] == b[7]) && (f[7] != a[7]), 1'b0, l[4]};
    endfunction

    task automatic preload(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        tl_we = 1'b1; tl_addr = a; tl_wdata = v;
        @(negedge clk);
        tl_we = 1'b0;
        mdl[a] = v;
    endtask

    // driver: model the add from the requirements, push the expectation, send the bytes
    task automatic run_add(input logic [7:0] op, input logic [7:0] x, input logic [7:0] y,
                           input int gap, input string req);
        exp_t       it;
        logic [7:0] b;
        int         n, len;
        it.chk_src = 1'b1;
        case (op)
            8'h02: begin it.d = wr_base + {4'h0, x[7:4]}; it.sa = wr_base + {4'h0, x[3:0]}; n = 4; len = 2; end
            8'h03: begin it.d = wr_base + {4'h0, x[7:4]}; it.sa = mdl[wr_base + {4'h0, x[3:0]}]; n = 6; len = 2; end
            8'h04: begin it.d = y; it.sa = x; n = 6; len = 3; end
            8'h05: begin it.d = y; it.sa = mdl[x]; n = 6; len = 3; end
            default: begin it.d = x; it.sa = x; it.chk_src = 1'b0; n = 6; len = 3; end
        endcase
        b = (op == 8'h06) ? y : mdl[it.sa];
        if (it.sa == it.d) it.chk_src = 1'b0;
        it.sv  = mdl[it.sa];
        it.v   = mdl[it.d] + b;
        it.fl  = exp_flags(mdl[it.d], b);
        it.req = req;
        mdl[it.d] = it.v;

        @(negedge clk);
        in_valid = 1'b1; in_byte = op;
        @(negedge clk);
        it.due = cyc + n - 1 + gap;
        sb.push_back(it);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
        in_valid = 1'b1; in_byte = x;
        @(negedge clk);
        if (len == 3) begin
            in_byte = y;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R8 in_ready after last byte", int'(in_ready), 0);
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pop the next expectation when done shows up
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected done", 1, 0);
            end else begin
                exp_t it;
                it = sb.pop_front();
                chk(cyc == it.due, {it.req, " R7 done cycle"}, cyc, it.due);
                chk(flags == it.fl, {it.req, " R2/R3 flags"}, int'(flags), int'(it.fl));
                tl_raddr = it.d;
                #1;
                chk(tl_rdata == it.v, {it.req, " R1 destination"}, int'(tl_rdata), int'(it.v));
                if (it.chk_src) begin
                    tl_raddr = it.sa;
                    #1;
                    chk(tl_rdata == it.sv, {it.req, " R1 source unchanged"}, int'(tl_rdata), int'(it.sv));
                end
            end
        end
    end

    task automatic illegal(input logic [7:0] op);
        logic [5:0] fb;
        fb = flags;
        @(negedge clk);
        in_valid = 1'b1; in_byte = op;
        @(negedge clk);
        in_valid = 1'b0;
        chk(err == 1'b1, "R9 err pulse", int'(err), 1);
        chk(done == 1'b0, "R9 no done", int'(done), 0);
        chk(in_ready == 1'b1, "R9 ready stays high", int'(in_ready), 1);
        @(negedge clk);
        chk(err == 1'b0, "R9 err one clock", int'(err), 0);
        chk(flags == fb, "R9 flags kept", int'(flags), int'(fb));
        tl_raddr = 8'h01;
        #1;
        chk(tl_rdata == mdl[8'h01], "R9 register kept", int'(tl_rdata), int'(mdl[8'h01]));
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!ended) begin
            ended = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(flags == 6'd0, "R11 flags", int'(flags), 0);
        chk(done == 1'b0 && err == 1'b0, "R11 done/err", int'({done, err}), 0);
        chk(in_ready == 1'b1, "R11 ready", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        tl_raddr = 8'h77;
        #1;
        chk(tl_rdata == 8'h00, "R11 register cleared", int'(tl_rdata), 0);

        preload(8'h01, 8'h21); preload(8'h02, 8'h03); preload(8'h03, 8'h0A);
        tl_raddr = 8'h03;
        #1;
        chk(tl_rdata == 8'h0A, "R10 test load", int'(tl_rdata), 8'h0A);

        run_add(8'h04, 8'h02, 8'h01, 0, "R5 abs+abs");
        chk(mdl[8'h01] == 8'h24, "R5 model 24h", int'(mdl[8'h01]), 8'h24);
        preload(8'h01, 8'h21);
        run_add(8'h05, 8'h02, 8'h01, 0, "R5 abs+ptr");
        chk(mdl[8'h01] == 8'h2B, "R5 model 2Bh", int'(mdl[8'h01]), 8'h2B);
        preload(8'h01, 8'h21);
        run_add(8'h06, 8'h01, 8'h25, 0, "R6 immediate");
        chk(mdl[8'h01] == 8'h46, "R6 model 46h", int'(mdl[8'h01]), 8'h46);

        preload(8'hC1, 8'h12); preload(8'hC2, 8'h03);
        run_add(8'h02, 8'h12, 8'h00, 0, "R4 work+work");
        chk(mdl[8'hC1] == 8'h15, "R4 model 15h", int'(mdl[8'hC1]), 8'h15);
        preload(8'hC1, 8'h12);
        run_add(8'h03, 8'h12, 8'h00, 0, "R4 work+ptr");
        chk(mdl[8'hC1] == 8'h1C, "R4 model 1Ch", int'(mdl[8'hC1]), 8'h1C);

        preload(8'h10, 8'hFF); preload(8'h11, 8'h01);
        run_add(8'h04, 8'h11, 8'h10, 0, "R2 carry zero half");
        preload(8'h12, 8'h7F);
        run_add(8'h06, 8'h12, 8'h01, 0, "R3 positive overflow");
        preload(8'h13, 8'h80); preload(8'h14, 8'h80);
        run_add(8'h04, 8'h14, 8'h13, 0, "R3 negative overflow");
        preload(8'h15, 8'hF0); preload(8'h16, 8'h90);
        run_add(8'h04, 8'h16, 8'h15, 0, "R3 no overflow with carry");
        preload(8'h20, 8'h40);
        run_add(8'h04, 8'h20, 8'h20, 0, "R1 same location");

        preload(8'hC5, 8'h3C); preload(8'hC6, 8'h0C);
        run_add(8'h02, 8'h56, 8'h00, 3, "R7 stall short form");
        run_add(8'h06, 8'h30, 8'h99, 2, "R7 stall long form");

        wr_base = 8'h50;
        preload(8'h51, 8'h08); preload(8'h52, 8'h08);
        run_add(8'h02, 8'h12, 8'h00, 0, "R4 new base");

        illegal(8'h07);
        illegal(8'h00);
        illegal(8'hFF);
        preload(8'h01, 8'h21);
        run_add(8'h06, 8'h01, 8'h01, 0, "R9 legal after illegal");

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule